// File: doc/BRIEF.md
# Parallel ATA Register Access Engine

This block is the host-side engine that runs single programmed-I/O accesses to the task-file registers of a parallel ATA device. The controller gives it one request at a time. Each request holds a two-line chip-select pattern, a three-bit register index, a direction flag and a 16-bit write word. The engine drives the address and runs a fixed timing sequence: a setup phase, an active-low strobe of programmable width, and a recovery phase. Every access ends with a one-cycle done pulse. For a read, the word sampled from the device is returned with that pulse.

The engine drives the data pins only while a write is in progress, and the output-enable tells the pad ring when to do so. It has a second mode that waits for the device to become ready. In that mode the engine ignores the given address and direction. It reads the status register (index 7, chip-select pattern CS0 low / CS1 high) again and again until the busy bit (bit 7) and the data-request bit (bit 3) are both zero. A budget limits the number of reads. When the budget runs out, the access still ends, and an error flag is raised.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset and whenever no access is running, both strobes are high, the data output-enable is low, busy and done are low, and both chip-select lines are high (`bus_cs` = 2'b11).
- R2: A write presents `bus_cs`, `bus_da` and `bus_dq_out` for SETUP_CYC cycles with both strobes high. It then holds `bus_wr_n` low for exactly STROBE_CYC cycles and keeps address and data unchanged for RECOV_CYC more cycles.
- R3: `bus_dq_oe` is high in every setup, strobe and recovery cycle of a write, and low in every other cycle, including all read cycles.
- R4: A read holds `bus_rd_n` low for exactly STROBE_CYC cycles after SETUP_CYC setup cycles. `rdata` returns all 16 bits that `bus_dq_in` carried in the last low cycle of the strobe.
- R5: `done` is high for exactly one cycle, SETUP_CYC+STROBE_CYC+RECOV_CYC cycles after the clock edge that accepted the request. `busy` is high from that edge through the done cycle.
- R6: A request raised while busy is high is dropped. It starts no access and changes neither the running access nor the registers it targets.
- R7: In poll mode (`req_poll`=1) every read targets `bus_cs`=2'b10 and `bus_da`=3'b111. Reads repeat back to back, each one full access long. The access ends after the first read whose bits 7 and 3 are both zero, and `rdata` holds that status word. Other status bits (for example bit 0 and bit 6) do not extend polling.
- R8: If POLL_LIMIT poll reads all show bit 7 or bit 3 set, the access ends after the last of them with `poll_err` high in the done cycle. `poll_err` stays high until the next accepted request clears it.
- R9: `bus_rd_n` and `bus_wr_n` are never low in the same cycle.
- R10: In poll mode `req_write`, `req_cs` and `req_addr` have no effect: no write strobe occurs and the data pins stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_poll | input | 1 | 1 = status-poll mode |
| req_cs | input | 2 | Chip-select line levels {CS1, CS0} |
| req_addr | input | 3 | Register index for DA2..DA0 |
| req_wdata | input | DATA_W | Write word |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Last sampled read word |
| poll_err | output | 1 | Poll budget exhausted |
| bus_cs | output | 2 | Chip-select lines {CS1, CS0} |
| bus_da | output | 3 | Register address lines |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dq_out | output | DATA_W | Data driven toward the device |
| bus_dq_oe | output | 1 | Output-enable for the data pads |
| bus_dq_in | input | DATA_W | Data received from the device |

## Verification
Each access's timing is fixed once the request edge is known. Setup occupies cycles 1 to SETUP_CYC after the accepting edge, and the strobe and recovery follow. `done` and the read result arrive in cycle SETUP_CYC+STROBE_CYC+RECOV_CYC+1. A poll of N reads ends in cycle N times that access length plus one. The bench raises each request just before a rising edge. It then records every port on each following falling edge into a per-cycle trace and compares that trace, index by index, with the windows computed from its own copies of the three timing parameters. The read value, the error flag and the done position are taken from the same trace entry in which `done` is seen.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV,
    PH_DONE
  } phase_t;

  // chip-select line levels, {CS1, CS0}
  localparam logic [1:0] CS_IDLE     = 2'b11;
  localparam logic [1:0] CS_TASKFILE = 2'b10;
  localparam logic [2:0] STATUS_IDX  = 3'd7;
  localparam int unsigned BSY_BIT = 7;
  localparam int unsigned DRQ_BIT = 3;

  function automatic logic status_ready(input logic [7:0] st);
    return !st[BSY_BIT] && !st[DRQ_BIT];
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ata_pio_phase_timer.sv
module ata_pio_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  assign last = (cnt == len - CNT_W'(1));
endmodule

// File: rtl/ata_pio_poll_budget.sv
module ata_pio_poll_budget #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned W     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic expired
);
  logic [W-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     used <= '0;
    else if (clear) used <= '0;
    else if (bump)  used <= used + W'(1);
  end

  // high while the read in flight is the last one the budget allows
  assign expired = (used == W'(LIMIT - 1));
endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned RECOV_CYC  = 2,
  parameter int unsigned CNT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_poll,
  input  logic [1:0]        req_cs,
  input  logic [2:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_dq_in,
  input  logic              ph_last,
  input  logic              poll_expired,
  output logic [CNT_W-1:0]  ph_len,
  output logic              tmr_restart,
  output logic              poll_clear,
  output logic              poll_bump,
  output logic              sample_evt,
  output logic              poll_active,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              poll_err,
  output logic [1:0]        bus_cs,
  output logic [2:0]        bus_da,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dq_out,
  output logic              bus_dq_oe
);
  phase_t            phase;
  logic              wr_q, poll_q, err_q;
  logic [1:0]        cs_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              accept, recov_end, not_ready, in_strobe, in_access;

  assign accept     = req_valid && (phase == PH_IDLE);
  assign in_strobe  = (phase == PH_STROBE);
  assign in_access  = (phase == PH_SETUP) || in_strobe || (phase == PH_RECOV);
  assign recov_end  = (phase == PH_RECOV) && ph_last;
  assign not_ready  = poll_q && !status_ready(rd_q[7:0]);
  assign sample_evt = in_strobe && ph_last && !wr_q;
  assign poll_clear = accept;
  assign poll_bump  = recov_end && not_ready && !poll_expired;
  assign tmr_restart = (phase == PH_IDLE) || (phase == PH_DONE) || ph_last;

  always_comb begin
    case (phase)
      PH_SETUP:  ph_len = CNT_W'(SETUP_CYC);
      PH_STROBE: ph_len = CNT_W'(STROBE_CYC);
      PH_RECOV:  ph_len = CNT_W'(RECOV_CYC);
      default:   ph_len = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      wr_q   <= 1'b0;
      poll_q <= 1'b0;
      err_q  <= 1'b0;
      cs_q   <= CS_IDLE;
      da_q   <= '0;
      wd_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_SETUP;
          wr_q   <= req_write && !req_poll;
          poll_q <= req_poll;
          err_q  <= 1'b0;
          cs_q   <= req_poll ? CS_TASKFILE : req_cs;
          da_q   <= req_poll ? STATUS_IDX : req_addr;
          wd_q   <= req_wdata;
        end
        PH_SETUP:  if (ph_last) phase <= PH_STROBE;
        PH_STROBE: if (ph_last) phase <= PH_RECOV;
        PH_RECOV: if (ph_last) begin
          if (not_ready && !poll_expired) begin
            phase <= PH_SETUP;
          end else begin
            phase <= PH_DONE;
            err_q <= not_ready;
          end
        end
        PH_DONE: begin
          phase <= PH_IDLE;
          cs_q  <= CS_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_q <= '0;
    else if (sample_evt) rd_q <= bus_dq_in;
  end

  assign bus_wr_n    = !(in_strobe && wr_q);
  assign bus_rd_n    = !(in_strobe && !wr_q);
  assign bus_dq_oe   = wr_q && in_access;
  assign bus_dq_out  = wd_q;
  assign bus_cs      = cs_q;
  assign bus_da      = da_q;
  assign busy        = (phase != PH_IDLE);
  assign done        = (phase == PH_DONE);
  assign rdata       = rd_q;
  assign poll_err    = err_q;
  assign poll_active = poll_q && busy;
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned RECOV_CYC  = 2,
  parameter int unsigned POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_poll,
  input  logic [1:0]        req_cs,
  input  logic [2:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              poll_err,
  output logic [1:0]        bus_cs,
  output logic [2:0]        bus_da,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dq_out,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_in
);
  localparam int unsigned MAX_PH = max3(SETUP_CYC, STROBE_CYC, RECOV_CYC);
  localparam int unsigned CNT_W  = $clog2(MAX_PH + 1);
  localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);

  // internal events, named for the bound checker
  logic [CNT_W-1:0] ph_len;
  logic             ph_last, tmr_restart;
  logic             poll_clear, poll_bump, poll_expired;
  logic             sample_evt, poll_active;

  ata_pio_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .len(ph_len), .last(ph_last)
  );

  ata_pio_poll_budget #(.LIMIT(POLL_LIMIT), .W(POLL_W)) budget_i (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .bump(poll_bump), .expired(poll_expired)
  );

  ata_pio_fsm #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .RECOV_CYC(RECOV_CYC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_poll(req_poll),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_dq_in(bus_dq_in), .ph_last(ph_last), .poll_expired(poll_expired),
    .ph_len(ph_len), .tmr_restart(tmr_restart),
    .poll_clear(poll_clear), .poll_bump(poll_bump),
    .sample_evt(sample_evt), .poll_active(poll_active),
    .busy(busy), .done(done), .rdata(rdata), .poll_err(poll_err),
    .bus_cs(bus_cs), .bus_da(bus_da), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe)
  );
endmodule

// File: rtl/ata_pio_engine_chk.sv
module ata_pio_engine_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned STROBE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              poll_err,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_dq_oe,
  input logic [1:0]        bus_cs,
  input logic [2:0]        bus_da,
  input logic [DATA_W-1:0] bus_dq_out,
  input logic              poll_active,
  input logic              sample_evt
);
  logic        strobe_low;
  logic [31:0] low_run;

  assign strobe_low = !bus_rd_n || !bus_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (strobe_low) low_run <= low_run + 32'd1;
    else                 low_run <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_rd_n && bus_wr_n && !bus_dq_oe && !done)); // R1

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_cs) && $stable(bus_da) && $stable(bus_dq_out))); // R2

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_low && low_run != 32'd0) |-> (low_run == STROBE_CYC)); // R2

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_dq_oe); // R3

  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_dq_oe); // R3

  AST_SAMPLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !bus_rd_n); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R5

  AST_POLL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_active && !bus_rd_n) |-> (bus_cs == 2'b10 && bus_da == 3'd7)); // R7

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_err) |-> done); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R9

  AST_POLL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> (bus_wr_n && !bus_dq_oe)); // R10
endmodule

bind ata_pio_engine ata_pio_engine_chk #(
  .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .poll_err(poll_err),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dq_oe(bus_dq_oe),
  .bus_cs(bus_cs), .bus_da(bus_da), .bus_dq_out(bus_dq_out),
  .poll_active(poll_active), .sample_evt(sample_evt)
);

// File: tb/ata_pio_engine_tb.sv
module ata_pio_engine_tb_top;
  localparam int CLK_P   = 10;
  localparam int B_S     = 2;
  localparam int B_W     = 3;
  localparam int B_R     = 2;
  localparam int B_LIMIT = 5;
  localparam int ACC     = B_S + B_W + B_R;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_poll = 1'b0;
  logic [1:0]  req_cs = 2'b10;
  logic [2:0]  req_addr = 3'd0;
  logic [15:0] req_wdata = 16'h0;
  logic        busy, done, poll_err;
  logic [15:0] rdata;
  logic [1:0]  bus_cs;
  logic [2:0]  bus_da;
  logic        bus_rd_n, bus_wr_n, bus_dq_oe;
  logic [15:0] bus_dq_out, bus_dq_in;

  int n_cmp = 0;
  int n_bad = 0;
  int excl_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ata_pio_engine #(
    .DATA_W(16), .SETUP_CYC(B_S), .STROBE_CYC(B_W), .RECOV_CYC(B_R), .POLL_LIMIT(B_LIMIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_poll(req_poll), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .poll_err(poll_err),
    .bus_cs(bus_cs), .bus_da(bus_da), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in)
  );

  // device model
  logic [15:0] dev_regs [0:7];
  logic [15:0] stat_seq [0:7];
  logic        model_on = 1'b0;
  logic        seq_mode = 1'b0;
  int          rd_rises = 0;
  int          seq_base = 0;

  always @(posedge bus_rd_n) if (model_on) rd_rises = rd_rises + 1;
  always @(posedge bus_wr_n) if (model_on) dev_regs[bus_da] <= bus_dq_out;

  always_comb begin
    if (bus_rd_n)                          bus_dq_in = 16'hDEAD;
    else if (seq_mode && bus_da == 3'd7)   bus_dq_in = stat_seq[3'(rd_rises - seq_base)];
    else                                   bus_dq_in = dev_regs[bus_da];
  end

  always @(negedge clk) if (model_on && !bus_rd_n && !bus_wr_n) excl_bad = excl_bad + 1;

  // per-cycle trace of one access
  logic        tr_wr [0:255];
  logic        tr_rd [0:255];
  logic        tr_oe [0:255];
  logic        tr_busy [0:255];
  logic        tr_done [0:255];
  logic        tr_err [0:255];
  logic [1:0]  tr_cs [0:255];
  logic [2:0]  tr_da [0:255];
  logic [15:0] tr_dq [0:255];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_access(input logic w, input logic p, input logic [1:0] cs,
                            input logic [2:0] da, input logic [15:0] wd,
                            input bit poke, output int n);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_poll = p;
    req_cs = cs; req_addr = da; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (n < 250) begin
      n++;
      tr_wr[n] = bus_wr_n; tr_rd[n] = bus_rd_n; tr_oe[n] = bus_dq_oe;
      tr_busy[n] = busy; tr_done[n] = done; tr_err[n] = poll_err;
      tr_cs[n] = bus_cs; tr_da[n] = bus_da; tr_dq[n] = bus_dq_out;
      if (poke && n == 2) begin
        req_valid = 1'b1; req_write = ~w; req_addr = ~da; req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      if (done) break;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (n >= 250) chk("R5", "access never finished", 0, 1);
  endtask

  task automatic check_trace(input string r_stb, input int n, input int reads, input logic w,
                             input logic [1:0] cs, input logic [2:0] da, input logic [15:0] dq);
    int bad_stb = 0, bad_oe = 0, bad_addr = 0, bad_busy = 0;
    for (int i = 1; i <= reads * ACC; i++) begin
      int ph;
      logic in_stb;
      ph = (i - 1) % ACC;
      in_stb = (ph >= B_S) && (ph < B_S + B_W);
      if (tr_wr[i] !== !(w && in_stb)) bad_stb++;
      if (tr_rd[i] !== !(!w && in_stb)) bad_stb++;
      if (tr_oe[i] !== w) bad_oe++;
      if (tr_cs[i] !== cs || tr_da[i] !== da || (w && tr_dq[i] !== dq)) bad_addr++;
      if (tr_busy[i] !== 1'b1 || tr_done[i] !== 1'b0) bad_busy++;
    end
    chk(r_stb, "strobe windows", bad_stb, 0);
    chk("R3", "data enable windows", bad_oe, 0);
    chk(r_stb, "address/data held", bad_addr, 0);
    chk("R5", "busy through access", bad_busy, 0);
    chk("R5", "done cycle index", n, reads * ACC + 1);
    chk("R3", "enable low at done", int'(tr_oe[n]), 0);
  endtask

  task automatic t_reset();
    chk("R1", "idle pins {rd_n,wr_n,oe,busy,done,err}",
        int'({bus_rd_n, bus_wr_n, bus_dq_oe, busy, done, poll_err}), 6'b110000);
    chk("R1", "chip selects idle", int'(bus_cs), 2'b11);
  endtask

  task automatic t_write_read_word();
    int n;
    run_access(1'b1, 1'b0, 2'b10, 3'd0, 16'hA55A, 1'b0, n);
    check_trace("R2", n, 1, 1'b1, 2'b10, 3'd0, 16'hA55A);
    @(negedge clk);
    chk("R5", "done single pulse", int'({done, busy}), 0);
    chk("R1", "chip selects back to idle", int'(bus_cs), 2'b11);
    run_access(1'b0, 1'b0, 2'b10, 3'd0, 16'h0, 1'b0, n);
    check_trace("R4", n, 1, 1'b0, 2'b10, 3'd0, 16'h0);
    chk("R4", "16-bit read word", int'(rdata), 16'hA55A);
  endtask

  task automatic t_other_regs();
    int n;
    run_access(1'b1, 1'b0, 2'b01, 3'd6, 16'h0002, 1'b0, n);
    check_trace("R2", n, 1, 1'b1, 2'b01, 3'd6, 16'h0002);
    run_access(1'b1, 1'b0, 2'b10, 3'd3, 16'h00C3, 1'b0, n);
    run_access(1'b0, 1'b0, 2'b10, 3'd3, 16'h0, 1'b0, n);
    chk("R4", "byte register read", int'(rdata), 16'h00C3);
  endtask

  task automatic t_busy_ignore();
    int n, extra;
    run_access(1'b1, 1'b0, 2'b10, 3'd4, 16'h1234, 1'b1, n);
    check_trace("R6", n, 1, 1'b1, 2'b10, 3'd4, 16'h1234);
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk("R6", "no access from dropped request", extra, 0);
    run_access(1'b0, 1'b0, 2'b10, 3'd3, 16'h0, 1'b0, n);
    chk("R6", "untouched register", int'(rdata), 16'h00C3);
    run_access(1'b0, 1'b0, 2'b10, 3'd4, 16'h0, 1'b0, n);
    chk("R6", "running write kept its data", int'(rdata), 16'h1234);
  endtask

  task automatic t_poll_ready();
    int n;
    stat_seq[0] = 16'h0080; stat_seq[1] = 16'h0088; stat_seq[2] = 16'h0008; stat_seq[3] = 16'h0050;
    seq_base = rd_rises; seq_mode = 1'b1;
    // write flag, control-block select and index 2 must all be ignored (R10)
    run_access(1'b1, 1'b1, 2'b01, 3'd2, 16'hFFFF, 1'b0, n);
    check_trace("R7", n, 4, 1'b0, 2'b10, 3'd7, 16'h0);
    chk("R7", "final status word", int'(rdata[7:0]), 8'h50);
    chk("R10", "no error and no write in poll", int'(tr_err[n]), 0);
    stat_seq[0] = 16'h0041;
    seq_base = rd_rises;
    run_access(1'b0, 1'b1, 2'b10, 3'd0, 16'h0, 1'b0, n);
    chk("R7", "check bit does not hold poll", n, ACC + 1);
    chk("R7", "single-read status", int'(rdata[7:0]), 8'h41);
    seq_mode = 1'b0;
  endtask

  task automatic t_poll_timeout();
    int n;
    for (int k = 0; k < 8; k++) stat_seq[k] = 16'h0080;
    seq_base = rd_rises; seq_mode = 1'b1;
    run_access(1'b0, 1'b1, 2'b10, 3'd0, 16'h0, 1'b0, n);
    check_trace("R8", n, B_LIMIT, 1'b0, 2'b10, 3'd7, 16'h0);
    chk("R8", "error in done cycle", int'(tr_err[n]), 1);
    chk("R8", "last status returned", int'(rdata[7:0]), 8'h80);
    seq_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "error held while idle", int'(poll_err), 1);
    run_access(1'b0, 1'b0, 2'b10, 3'd3, 16'h0, 1'b0, n);
    chk("R8", "error cleared by next request", int'(tr_err[1]), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    model_on = 1'b1;
    repeat (2) @(negedge clk);
    t_write_read_word();
    t_other_regs();
    t_busy_ignore();
    t_poll_ready();
    t_poll_timeout();
    chk("R9", "strobes never low together", excl_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule